// File: doc/BRIEF.md
# Phase-Continuous FFSK Tone Modulator

This block turns a serial bit stream into a stream of signed sine samples using fast frequency-shift keying, for a DAC that follows it. Each bit is sent as a fixed fraction of a sine cycle. At the low rate a one is a single full cycle and a zero is one and a half cycles at a higher pitch. At the two higher rates a one is half a cycle and a zero is one full cycle. Every bit therefore ends on a zero crossing. The phase runs on from bit to bit without being reset, so tone changes are seamless.

The block runs from one master clock, nominally 1.008 MHz or 4.032 MHz, selected by a pin. Two further pins pick 1200, 2400 or 4800 baud. A square-wave sync output paces the data source: the source changes its data while sync is low, and the block takes the bit at the instant sync would rise. An active-low enable starts the transmitter from phase zero. With the enable inactive, the sample-valid flag drops, standing in for a high-impedance output, and sync is held high.

Top module: `ffsk_tone_mod`

## Requirements
- R1: Rate and divider. With the slow clock (`clkRateSel`=0), 1200 baud gives 12 clocks per step and 2400 baud gives 6. With the fast clock (`clkRateSel`=1), 1200 baud gives 48, 2400 gives 24 and 4800 gives 12. Every bit lasts 70 steps. Mode selection:
  - `baudSel1200`=1 selects 1200 baud.
  - `baudSel1200`=0 with `baudSel4800`=0 selects 2400 baud.
  - `baudSel1200`=0 with `baudSel4800`=1 selects 4800 baud.
- R2: A full sine cycle is 140 phase steps. The phase advances once per step by the tone increment: at 1200 baud, 2 for a one and 3 for a zero; at 2400 or 4800 baud, 1 for a one and 2 for a zero.
- R3: The phase is never reset between bits. At every bit boundary it sits at 0 or 70, so the sample there is exactly zero.
- R4: `sampleOut` equals 2047·sin(2π·phase/140) within ±6 LSB. It is positive for phases below 70, negative above, and never reaches -2048.
- R5: While enabled, `txSync` is 1 for the first 35 steps of each bit and 0 for the last 35.
- R6: `txData` is captured only at the start of a bit (on the enabling edge, then at each bit boundary). Changes during a bit have no effect on that bit.
- R7: While `txEnN` is 1, `sampleValid` is 0, `txSync` is 1 and `sampleOut` is 0, from the first clock edge that sees it. Enabling again restarts at phase 0 with a fresh bit.
- R8: Decoding of pin combinations:
  - 4800 baud with the slow clock is unsupported: the block runs at 1200 baud with 12 clocks per step and sets `rateErr`.
  - With `baudSel1200`=1, the `baudSel4800` pin is ignored.
  - `rateErr` is 0 for every supported combination.
- R9: The rate pins are captured along with the data at bit start. A pin change during a bit does not alter that bit.
- R10: During reset, `txSync`=1, `sampleValid`=0, `sampleOut`=0 and `rateErr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (1.008 or 4.032 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| clkRateSel | input | 1 | 0 = slow master clock, 1 = fast (four times) |
| baudSel1200 | input | 1 | 1 = 1200 baud, 0 = 2400 or 4800 baud |
| baudSel4800 | input | 1 | With baudSel1200 = 0: 1 = 4800 baud |
| txEnN | input | 1 | Active-low transmit enable |
| txData | input | 1 | Serial data, one = mark |
| txSync | output | 1 | Bit-rate square wave pacing the data |
| sampleOut | output | SAMPLE_W | Signed sine sample |
| sampleValid | output | 1 | Output enabled (low = high-impedance state) |
| rateErr | output | 1 | Unsupported rate combination in use |

## Verification
Every rate combination, including the unsupported one and the one where the 4800 pin is ignored, runs four bits. The bit patterns are chosen so that each rate sees a mark followed by a space and a space followed by a mark; this separates increments 1/2/3 and exposes any phase reset at a boundary. A mid-bit inversion of the data and a mid-bit flip of the clock-rate pin tell a design that latches at bit start from one that follows its pins. An abort in mid-bit followed by re-enabling distinguishes a true restart from a resumed phase.

// File: rtl/ffsk_pkg.sv
package ffsk_pkg;

  typedef enum logic [1:0] {
    BAUD_1200 = 2'd0,
    BAUD_2400 = 2'd1,
    BAUD_4800 = 2'd2
  } baud_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       run;   // transmitter active
    logic       step;  // advance phase this cycle
    logic [1:0] inc;   // phase increment for current bit
  } dp_ctrl_s;

endpackage

// File: rtl/ffsk_rate_decode.sv
module ffsk_rate_decode
  import ffsk_pkg::*;
#(
  parameter int BASE_DIV  = 12,
  parameter int CLK_RATIO = 4,
  parameter int DIV_W     = 6
) (
  input  logic             fastClk,
  input  logic             sel1200,
  input  logic             sel4800,
  output baud_e            baud,
  output logic [DIV_W-1:0] divSel,
  output logic             badCombo
);

  localparam int SLOW_1200 = BASE_DIV;
  localparam int SLOW_2400 = BASE_DIV / 2;
  localparam int FAST_1200 = BASE_DIV * CLK_RATIO;
  localparam int FAST_2400 = BASE_DIV * CLK_RATIO / 2;
  localparam int FAST_4800 = BASE_DIV * CLK_RATIO / 4;

  always_comb begin
    badCombo = 1'b0;
    if (sel1200) begin
      baud = BAUD_1200;
    end else if (!sel4800) begin
      baud = BAUD_2400;
    end else if (fastClk) begin
      baud = BAUD_4800;
    end else begin
      baud     = BAUD_1200;   // fallback for slow clock at top rate
      badCombo = 1'b1;
    end
  end

  always_comb begin
    divSel = DIV_W'(SLOW_1200);
    if (fastClk) begin
      unique case (baud)
        BAUD_1200: divSel = DIV_W'(FAST_1200);
        BAUD_2400: divSel = DIV_W'(FAST_2400);
        default:   divSel = DIV_W'(FAST_4800);
      endcase
    end else begin
      divSel = (baud == BAUD_2400) ? DIV_W'(SLOW_2400) : DIV_W'(SLOW_1200);
    end
  end

endmodule

// File: rtl/ffsk_tx_ctrl.sv
module ffsk_tx_ctrl
  import ffsk_pkg::*;
#(
  parameter int TICKS_PER_BIT = 70,
  parameter int DIV_W         = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txEnN,
  input  logic             txData,
  input  baud_e            baudSel,
  input  logic [DIV_W-1:0] divSel,
  input  logic             badCombo,
  output dp_ctrl_s         ctrl,
  output logic             txSync,
  output logic             rateErr
);

  localparam int STEP_W   = $clog2(TICKS_PER_BIT);
  localparam int HALF_BIT = TICKS_PER_BIT / 2;

  logic             active;
  logic             dataBit;
  baud_e            baudReg;
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] tickCnt;
  logic [STEP_W-1:0] stepCnt;
  logic             tickDone;
  logic             lastStep;
  logic             loadBit;

  assign tickDone = active && (tickCnt == divReg - DIV_W'(1));
  assign lastStep = (stepCnt == STEP_W'(TICKS_PER_BIT - 1));
  assign loadBit  = !active || (tickDone && lastStep);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      dataBit <= 1'b0;
      baudReg <= BAUD_1200;
      divReg  <= divSel;
      rateErr <= 1'b0;
      tickCnt <= '0;
      stepCnt <= '0;
    end else begin
      active <= !txEnN;
      if (loadBit) begin
        dataBit <= txData;
        baudReg <= baudSel;
        divReg  <= divSel;
        rateErr <= badCombo;
      end
      if (!active) begin
        tickCnt <= '0;
        stepCnt <= '0;
      end else if (tickDone) begin
        tickCnt <= '0;
        stepCnt <= lastStep ? '0 : stepCnt + STEP_W'(1);
      end else begin
        tickCnt <= tickCnt + DIV_W'(1);
      end
    end
  end

  always_comb begin
    ctrl.run  = active;
    ctrl.step = tickDone;
    if (baudReg == BAUD_1200) ctrl.inc = dataBit ? 2'd2 : 2'd3;
    else                      ctrl.inc = dataBit ? 2'd1 : 2'd2;
  end

  assign txSync = !active || (stepCnt < STEP_W'(HALF_BIT));

endmodule

// File: rtl/ffsk_tx_datapath.sv
module ffsk_tx_datapath
  import ffsk_pkg::*;
#(
  parameter int STEPS_PER_CYCLE = 140,
  parameter int SAMPLE_W        = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dp_ctrl_s                   ctrl,
  output logic signed [SAMPLE_W-1:0] sampleOut
);

  localparam int     QUARTER = STEPS_PER_CYCLE / 4;
  localparam int     PH_W    = $clog2(STEPS_PER_CYCLE);
  localparam int     IDX_W   = $clog2(QUARTER + 1);
  localparam int     MAG_W   = SAMPLE_W - 1;
  localparam longint AMP     = (longint'(1) << MAG_W) - 1;

  // rational sine approximation over the first quadrant, angle = k/STEPS turns
  function automatic logic [MAG_W-1:0] quarterMag(input int k);
    longint halfTurn, x, prod, num, den;
    halfTurn = longint'(180) * STEPS_PER_CYCLE;
    x        = longint'(k) * 360;
    prod     = x * (halfTurn - x);
    den      = longint'(40500) * STEPS_PER_CYCLE * STEPS_PER_CYCLE - prod;
    num      = 4 * AMP * prod;
    return MAG_W'((num + den / 2) / den);
  endfunction

  logic [MAG_W-1:0] quarterTab [QUARTER+1];

  for (genvar g = 0; g <= QUARTER; g++) begin : g_qtab
    assign quarterTab[g] = quarterMag(g);
  end

  logic [PH_W-1:0]  phase;
  logic [PH_W:0]    phaseSum;
  logic [IDX_W-1:0] idx;
  logic [MAG_W-1:0] mag;
  logic             negHalf;

  assign phaseSum = {1'b0, phase} + (PH_W+1)'(ctrl.inc);

  always_ff @(posedge clk) begin
    if (rst || !ctrl.run) begin
      phase <= '0;
    end else if (ctrl.step) begin
      if (phaseSum >= (PH_W+1)'(STEPS_PER_CYCLE))
        phase <= PH_W'(phaseSum - (PH_W+1)'(STEPS_PER_CYCLE));
      else
        phase <= phaseSum[PH_W-1:0];
    end
  end

  always_comb begin
    negHalf = (phase >= PH_W'(2 * QUARTER));
    if (phase < PH_W'(QUARTER))
      idx = IDX_W'(phase);
    else if (phase < PH_W'(2 * QUARTER))
      idx = IDX_W'(PH_W'(2 * QUARTER) - phase);
    else if (phase < PH_W'(3 * QUARTER))
      idx = IDX_W'(phase - PH_W'(2 * QUARTER));
    else
      idx = IDX_W'(PH_W'(4 * QUARTER) - phase);
    mag = quarterTab[idx];
    if (!ctrl.run)
      sampleOut = '0;
    else if (negHalf)
      sampleOut = -$signed({1'b0, mag});
    else
      sampleOut = $signed({1'b0, mag});
  end

endmodule

// File: rtl/ffsk_tone_mod.sv
module ffsk_tone_mod
  import ffsk_pkg::*;
#(
  parameter int STEPS_PER_CYCLE = 140,
  parameter int SAMPLE_W        = 12,
  parameter int BASE_DIV        = 12,
  parameter int CLK_RATIO       = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clkRateSel,
  input  logic                       baudSel1200,
  input  logic                       baudSel4800,
  input  logic                       txEnN,
  input  logic                       txData,
  output logic                       txSync,
  output logic signed [SAMPLE_W-1:0] sampleOut,
  output logic                       sampleValid,
  output logic                       rateErr
);

  localparam int TICKS_PER_BIT = STEPS_PER_CYCLE / 2;
  localparam int DIV_W         = $clog2(BASE_DIV * CLK_RATIO + 1);

  baud_e            baudSel;
  logic [DIV_W-1:0] divSel;
  logic             badCombo;
  dp_ctrl_s         ctrl;

  ffsk_rate_decode #(
    .BASE_DIV (BASE_DIV),
    .CLK_RATIO(CLK_RATIO),
    .DIV_W    (DIV_W)
  ) rate_i (
    .fastClk (clkRateSel),
    .sel1200 (baudSel1200),
    .sel4800 (baudSel4800),
    .baud    (baudSel),
    .divSel  (divSel),
    .badCombo(badCombo)
  );

  ffsk_tx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .DIV_W        (DIV_W)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .txEnN   (txEnN),
    .txData  (txData),
    .baudSel (baudSel),
    .divSel  (divSel),
    .badCombo(badCombo),
    .ctrl    (ctrl),
    .txSync  (txSync),
    .rateErr (rateErr)
  );

  ffsk_tx_datapath #(
    .STEPS_PER_CYCLE(STEPS_PER_CYCLE),
    .SAMPLE_W       (SAMPLE_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .sampleOut(sampleOut)
  );

  assign sampleValid = ctrl.run;

endmodule

// File: rtl/ffsk_tone_mod_checker.sv
module ffsk_tone_mod_checker #(
  parameter int SAMPLE_W = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       clkRateSel,
  input logic                       baudSel1200,
  input logic                       baudSel4800,
  input logic                       txEnN,
  input logic                       txSync,
  input logic signed [SAMPLE_W-1:0] sampleOut,
  input logic                       sampleValid,
  input logic                       rateErr
);

  logic                       errPins;
  logic signed [SAMPLE_W-1:0] minNeg;

  assign errPins = !clkRateSel && !baudSel1200 && baudSel4800;
  assign minNeg  = {1'b1, {(SAMPLE_W-1){1'b0}}};

  // R7: idle outputs are quiet
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |-> (txSync && sampleOut == '0));

  // R7: disable takes effect on the first edge that sees it
  p_disable_next_r7: assert property (@(posedge clk) disable iff (rst)
    $past(txEnN) |-> !sampleValid);

  // R3: bit boundaries land on a zero crossing
  p_zero_cross_r3: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && $rose(txSync)) |-> sampleOut == '0);

  // R4: amplitude stays symmetric
  p_sample_bound_r4: assert property (@(posedge clk) disable iff (rst)
    sampleOut != minNeg);

  // R8: unsupported pins seen while idle raise the error flag
  p_cfg_err_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(txEnN) && $past(txEnN, 2) && $past(errPins)) |-> rateErr);

endmodule

bind ffsk_tone_mod ffsk_tone_mod_checker #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .clkRateSel (clkRateSel),
  .baudSel1200(baudSel1200),
  .baudSel4800(baudSel4800),
  .txEnN      (txEnN),
  .txSync     (txSync),
  .sampleOut  (sampleOut),
  .sampleValid(sampleValid),
  .rateErr    (rateErr)
);

// File: tb/ffsk_tone_mod_tb_top.sv
module ffsk_tone_mod_tb_top;

  localparam int SW    = 12;
  localparam int STEPS = 140;
  localparam int BITT  = 70;
  localparam int NV    = 7;
  localparam int TOL   = 6;

  typedef struct packed {
    logic       fast;
    logic       s12;
    logic       s48;
    logic [3:0] bits;   // bits[0] sent first
    int         div;
    logic       low;    // 1200-baud increments expected
    logic       err;
  } vec_s;

  localparam vec_s VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 4'b1010, 12, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 4'b0110,  6, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 4'b1100, 48, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 4'b0011, 24, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 4'b1001, 12, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 4'b0101, 12, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 4'b1110, 12, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clkRateSel = 1'b0, baudSel1200 = 1'b1, baudSel4800 = 1'b0;
  logic txEnN = 1'b1, txData = 1'b0;
  logic txSync, sampleValid, rateErr;
  logic signed [SW-1:0] sampleOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  ffsk_tone_mod dut_i (
    .clk(clk), .rst(rst), .clkRateSel(clkRateSel), .baudSel1200(baudSel1200),
    .baudSel4800(baudSel4800), .txEnN(txEnN), .txData(txData), .txSync(txSync),
    .sampleOut(sampleOut), .sampleValid(sampleValid), .rateErr(rateErr)
  );

  function automatic int sineRef(input int p);
    real a;
    a = 2047.0 * $sin(2.0 * 3.141592653589793 * p / STEPS);
    return (a >= 0.0) ? $rtoi(a + 0.5) : -$rtoi(-a + 0.5);
  endfunction

  function automatic int incOf(input logic low, input logic b);
    if (low) return b ? 2 : 3;
    return b ? 1 : 2;
  endfunction

  task automatic check(input string req, input int act, input int exp, input int tol);
    int d;
    nChecks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic checkIdle(input string req);
    check(req, int'(sampleValid), 0, 0);
    check(req, int'(txSync), 1, 0);
    check(req, int'(sampleOut), 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    vec_s cv;
    int   cum [5];
    int   d, t, b, s, ph;

    // R10: reset state
    repeat (3) @(negedge clk);
    checkIdle("R10");
    check("R10", int'(rateErr), 0, 0);
    rst = 1'b0;

    // table walk: every rate combination, four bits each
    for (int v = 0; v < NV; v++) begin
      cv = VECS[v];
      d  = cv.div;
      cum[0] = 0;
      for (int j = 0; j < 4; j++) cum[j+1] = cum[j] + BITT * incOf(cv.low, cv.bits[j]);
      @(negedge clk);
      clkRateSel = cv.fast; baudSel1200 = cv.s12; baudSel4800 = cv.s48;
      txEnN = 1'b1; txData = cv.bits[0];
      repeat (2) @(negedge clk);
      check("R8 idle flag", int'(rateErr), int'(cv.err), 0);
      checkIdle("R7 idle");
      txEnN = 1'b0;
      for (int n = 0; n < 4 * BITT * d; n++) begin
        @(negedge clk);
        t = n / d; b = t / BITT; s = t % BITT;
        if (n % d == 0) begin
          ph = (cum[b] + s * incOf(cv.low, cv.bits[b])) % STEPS;
          if (s == 0) check("R3 boundary zero", int'(sampleOut), 0, 0);
          else        check("R2 R4 R6 R9 sample", int'(sampleOut), sineRef(ph), TOL);
          check("R1 R5 sync", int'(txSync), (s < BITT/2) ? 1 : 0, 0);
          check("R7 valid", int'(sampleValid), 1, 0);
          check("R8 flag", int'(rateErr), int'(cv.err), 0);
        end
        if (n % (BITT * d) == 10 * d) txData = ~cv.bits[b];
        if (n % (BITT * d) == 20 * d) clkRateSel = ~cv.fast;
        if (n % (BITT * d) == 35 * d) txData = (b < 3) ? cv.bits[b+1] : 1'b0;
        if (n % (BITT * d) == 40 * d) clkRateSel = cv.fast;
      end
      txEnN = 1'b1;
      @(negedge clk);
      checkIdle("R7 disable");
    end

    // R7: abort mid-bit, then restart from phase 0
    clkRateSel = 1'b0; baudSel1200 = 1'b0; baudSel4800 = 1'b0;
    txData = 1'b1; txEnN = 1'b0;
    repeat (100) @(negedge clk);
    txEnN = 1'b1;
    @(negedge clk);
    checkIdle("R7 abort");
    txData = 1'b0;
    @(negedge clk);
    txEnN = 1'b0;
    repeat (7) @(negedge clk);
    check("R7 restart sample", int'(sampleOut), sineRef(2), TOL);
    check("R7 restart sync", int'(txSync), 1, 0);
    txEnN = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule